// File: doc/BRIEF.md
# Fan Tachometer Supervisor

This block watches a fan's tachometer line and turns it into a speed reading. The reading is the number of reference ticks between two rising edges of the tachometer signal, so a larger number means a slower fan. The block compares the reading with a programmed target and raises a status bit when the fan runs outside a ±20% window. A second status bit shows a fan slower than a fixed low-speed limit. The reference tick is the system clock divided by a parameter.

When detection is enabled, the block also watches for a failed fan in two ways. One is a tachometer line that stops rising for a long timeout. The other is a run of consecutive measurements that all saturate at the largest count. A failure sets a status bit and drives the active-low alert output. Both stay latched until software first clears the detect-enable bit and then sends an alert-response acknowledge. Register access arrives as single-cycle strobes from a serial-bus engine, which lies outside this block.

Top module: `fanTachSup`

## Requirements
- R1: After reset the target count reads 0xFF, the actual count reads 0xFF, the status byte reads 0x02 and alertN is 1.
- R2: A cycle with wrTargetStb high loads targetIn into the target count, and targetCnt shows it from the next cycle on. A cycle with wrCfgStb high loads cfgIn into the detect-enable flag.
- R3: The input passes a two-flop synchronizer. The first rising edge after reset only arms the measurement. Each later rising edge stores min(255, floor((P-1)/TICK_DIV)) in actualCnt, where P is the spacing between the last two rising edges of fgIn in clock cycles. The stored value is visible within three cycles of the edge.
- R4: Status bit 0 is 1 exactly when actualCnt > target + target/5 or actualCnt < target - target/5. The division is an integer division.
- R5: Status bit 1 is 1 exactly when actualCnt > SLOW_CNT, the count that corresponds to 1920 rpm.
- R6: While detect-enable is 0, no failure is declared, however long the line stays idle.
- R7: While detect-enable is 1, a failure is declared when no rising edge is seen for STALL_CYC clock cycles. A failure sets status bit 2 to 1 and drives alertN to 0.
- R8: While detect-enable is 1, a failure is declared when SAT_RUN consecutive measurements equal 255. Any measurement below 255 restarts that run.
- R9: A latched failure clears (status bit 2 to 0, alertN to 1) only on ackStb while detect-enable is 0. An acknowledge while detect-enable is 1 has no effect. Clearing detect-enable alone does not clear the failure.
- R10: Status bits 7 to 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| fgIn | input | 1 | Raw tachometer pulse line (asynchronous) |
| wrTargetStb | input | 1 | Write strobe for the target count |
| targetIn | input | CNT_W | Data for a target-count write |
| wrCfgStb | input | 1 | Write strobe for the detect-enable flag |
| cfgIn | input | 1 | Data for a detect-enable write |
| ackStb | input | 1 | Alert-response acknowledge strobe |
| targetCnt | output | CNT_W | Target count readback |
| actualCnt | output | CNT_W | Last measured period count |
| statusByte | output | 8 | Bit 0 outside window, bit 1 too slow, bit 2 fan failure |
| alertN | output | 1 | Active-low failure alert |

## Verification
The assertions assume that every strobe lasts a single clock cycle. They also assume that the tachometer line, once synchronized, stays high or low for at least one full clock cycle, so that each rising edge gives exactly one measurement. The bench drives all strobes for exactly one cycle at the falling clock edge. It builds every tachometer period from a high phase of two cycles and a low phase of at least one cycle. The bench keeps the spacing between edges in the failure tests well below the stall timeout, so the only failure it expects is the one it sets up on purpose.

// File: rtl/fanTachPkg.sv
package fanTachPkg;

  // Events from the datapath to the failure control.
  typedef struct packed {
    logic stallHit;   // no rising edge for the full timeout
    logic satHit;     // saturated-measurement run reached its limit
    logic detEn;      // detect-enable flag as held in the datapath
  } dpEvt_t;

  // Strobes from the failure control back to the datapath.
  typedef struct packed {
    logic restartMon; // clear the stall and saturation monitors
  } ctlCmd_t;

  typedef enum logic {
    ST_WATCH  = 1'b0,
    ST_FAILED = 1'b1
  } ctlState_t;

endpackage

// File: rtl/fanTachDatapath.sv
module fanTachDatapath
  import fanTachPkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TICK_DIV  = 4,
  parameter int STALL_CYC = 25000000,
  parameter int SAT_RUN   = 8,
  parameter int SLOW_CNT  = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fgIn,
  input  logic             wrTargetStb,
  input  logic [CNT_W-1:0] targetIn,
  input  logic             wrCfgStb,
  input  logic             cfgIn,
  input  ctlCmd_t          cmd,
  output dpEvt_t           evt,
  output logic [CNT_W-1:0] actualCnt,
  output logic [CNT_W-1:0] targetCnt,
  output logic             outOfWindow,
  output logic             tooSlow
);

  localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int STALL_W = $clog2(STALL_CYC + 1);
  localparam int RUN_W   = $clog2(SAT_RUN + 1);
  localparam int EXT_W   = CNT_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Synchronizer and rising-edge detect
  logic fgMeta, fgSync, fgPrev, fgRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fgMeta <= 1'b0;
      fgSync <= 1'b0;
      fgPrev <= 1'b0;
    end else begin
      fgMeta <= fgIn;
      fgSync <= fgMeta;
      fgPrev <= fgSync;
    end
  end

  assign fgRise = fgSync && !fgPrev;

  // Registers written by software
  logic detEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetCnt <= CNT_MAX;
      detEn     <= 1'b0;
    end else begin
      if (wrTargetStb) targetCnt <= targetIn;
      if (wrCfgStb)    detEn     <= cfgIn;
    end
  end

  // Reference tick and period counter, both restarted on each edge
  logic [PRE_W-1:0] preCnt;
  logic             refTick;
  logic [CNT_W-1:0] periodCnt;
  logic             armed;
  logic             measDone;

  assign refTick  = (preCnt == PRE_W'(TICK_DIV - 1));
  assign measDone = fgRise && armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      periodCnt <= '0;
      armed     <= 1'b0;
      actualCnt <= CNT_MAX;
    end else if (fgRise) begin
      preCnt    <= '0;
      periodCnt <= '0;
      armed     <= 1'b1;
      if (armed) actualCnt <= periodCnt;
    end else begin
      preCnt <= refTick ? '0 : preCnt + 1'b1;
      if (refTick && periodCnt != CNT_MAX) periodCnt <= periodCnt + 1'b1;
    end
  end

  a_r3_hold_between_edges : assert property (@(posedge clk) disable iff (!rstN)
    !measDone |=> $stable(actualCnt));

  // Stall monitor
  logic [STALL_W-1:0] stallCnt;
  logic               stallHit;

  assign stallHit = detEn && !fgRise && (stallCnt == STALL_W'(STALL_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !detEn || fgRise || cmd.restartMon) begin
      stallCnt <= '0;
    end else if (!stallHit) begin
      stallCnt <= stallCnt + 1'b1;
    end
  end

  a_r7_stall_bound : assert property (@(posedge clk) disable iff (!rstN)
    stallCnt < STALL_W'(STALL_CYC));

  a_r6_stall_idle_off : assert property (@(posedge clk) disable iff (!rstN)
    !detEn |=> stallCnt == '0);

  // Saturated-measurement run monitor
  logic [RUN_W-1:0] satRun;
  logic             satMeas;
  logic             satHit;

  assign satMeas = measDone && (periodCnt == CNT_MAX);
  assign satHit  = detEn && satMeas && (satRun == RUN_W'(SAT_RUN - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !detEn || cmd.restartMon) begin
      satRun <= '0;
    end else if (measDone) begin
      if (!satMeas)     satRun <= '0;
      else if (!satHit) satRun <= satRun + 1'b1;
    end
  end

  a_r8_run_bound : assert property (@(posedge clk) disable iff (!rstN)
    satRun < RUN_W'(SAT_RUN));

  a_r8_run_restart : assert property (@(posedge clk) disable iff (!rstN)
    (measDone && !satMeas) |=> satRun == '0);

  // Speed window and low-speed compare
  logic [EXT_W-1:0] tgtExt, actExt, margin, hiLim, loLim;

  always_comb begin
    tgtExt      = EXT_W'(targetCnt);
    actExt      = EXT_W'(actualCnt);
    margin      = tgtExt / EXT_W'(5);
    hiLim       = tgtExt + margin;
    loLim       = tgtExt - margin;
    outOfWindow = (actExt > hiLim) || (actExt < loLim);
    tooSlow     = (actualCnt > CNT_W'(SLOW_CNT));
  end

  assign evt.stallHit = stallHit;
  assign evt.satHit   = satHit;
  assign evt.detEn    = detEn;

endmodule

// File: rtl/fanTachControl.sv
module fanTachControl
  import fanTachPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpEvt_t  evt,
  input  logic    ackStb,
  output ctlCmd_t cmd,
  output logic    failFlag
);

  ctlState_t state, stateNext;
  logic      clearOk;

  assign clearOk = ackStb && !evt.detEn;

  always_comb begin
    stateNext      = state;
    cmd.restartMon = 1'b0;
    unique case (state)
      ST_WATCH: begin
        if (evt.detEn && (evt.stallHit || evt.satHit)) begin
          stateNext      = ST_FAILED;
          cmd.restartMon = 1'b1;
        end
      end
      ST_FAILED: begin
        if (clearOk) stateNext = ST_WATCH;
      end
      default: stateNext = ST_WATCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_WATCH;
    else       state <= stateNext;
  end

  assign failFlag = (state == ST_FAILED);

  a_r6_no_fail_when_off : assert property (@(posedge clk) disable iff (!rstN)
    !evt.detEn |=> !$rose(failFlag));

  a_r7_fail_has_cause : assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> $past(evt.stallHit || evt.satHit));

  a_r9_fail_sticky : assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !clearOk) |=> failFlag);

  a_r9_clear_needs_off : assert property (@(posedge clk) disable iff (!rstN)
    $fell(failFlag) |-> $past(ackStb && !evt.detEn));

endmodule

// File: rtl/fanTachSup.sv
module fanTachSup
  import fanTachPkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TICK_DIV  = 4,
  parameter int STALL_CYC = 25000000,
  parameter int SAT_RUN   = 8,
  parameter int SLOW_CNT  = 200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fgIn,
  input  logic             wrTargetStb,
  input  logic [CNT_W-1:0] targetIn,
  input  logic             wrCfgStb,
  input  logic             cfgIn,
  input  logic             ackStb,
  output logic [CNT_W-1:0] targetCnt,
  output logic [CNT_W-1:0] actualCnt,
  output logic [7:0]       statusByte,
  output logic             alertN
);

  dpEvt_t  evt;
  ctlCmd_t cmd;
  logic    outOfWindow, tooSlow, failFlag;

  fanTachDatapath #(
    .CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .STALL_CYC(STALL_CYC),
    .SAT_RUN(SAT_RUN), .SLOW_CNT(SLOW_CNT)
  ) dp (
    .clk(clk), .rstN(rstN), .fgIn(fgIn),
    .wrTargetStb(wrTargetStb), .targetIn(targetIn),
    .wrCfgStb(wrCfgStb), .cfgIn(cfgIn),
    .cmd(cmd), .evt(evt),
    .actualCnt(actualCnt), .targetCnt(targetCnt),
    .outOfWindow(outOfWindow), .tooSlow(tooSlow)
  );

  fanTachControl ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .ackStb(ackStb),
    .cmd(cmd), .failFlag(failFlag)
  );

  assign statusByte = {5'b00000, failFlag, tooSlow, outOfWindow};
  assign alertN     = !failFlag;

  a_r7_alert_tracks_fail : assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusByte[2]) |-> !alertN);

endmodule

// File: tb/fanTachSup_test.sv
module fanTachSup_test;

  localparam int TDIV  = 2;
  localparam int STALL = 2000;
  localparam int RUN   = 8;
  localparam int SLOW  = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fgIn = 1'b0;
  logic       wrTargetStb = 1'b0;
  logic [7:0] targetIn = '0;
  logic       wrCfgStb = 1'b0;
  logic       cfgIn = 1'b0;
  logic       ackStb = 1'b0;
  logic [7:0] targetCnt, actualCnt, statusByte;
  logic       alertN;

  int checks = 0;
  int fails  = 0;

  always #10 clk = !clk;

  fanTachSup #(
    .CNT_W(8), .TICK_DIV(TDIV), .STALL_CYC(STALL),
    .SAT_RUN(RUN), .SLOW_CNT(SLOW)
  ) uut (
    .clk(clk), .rstN(rstN), .fgIn(fgIn),
    .wrTargetStb(wrTargetStb), .targetIn(targetIn),
    .wrCfgStb(wrCfgStb), .cfgIn(cfgIn), .ackStb(ackStb),
    .targetCnt(targetCnt), .actualCnt(actualCnt),
    .statusByte(statusByte), .alertN(alertN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One tachometer period: rise, two cycles high, then low.
  task automatic fgPeriod(input int p);
    fgIn = 1'b1;
    tick(2);
    fgIn = 1'b0;
    tick(p - 2);
  endtask

  task automatic setTarget(input int v);
    targetIn = 8'(v);
    wrTargetStb = 1'b1;
    tick(1);
    wrTargetStb = 1'b0;
  endtask

  task automatic setDet(input logic b);
    cfgIn = b;
    wrCfgStb = 1'b1;
    tick(1);
    wrCfgStb = 1'b0;
  endtask

  task automatic pulseAck();
    ackStb = 1'b1;
    tick(1);
    ackStb = 1'b0;
  endtask

  function automatic int expCnt(input int p);
    int c = (p - 1) / TDIV;
    return (c > 255) ? 255 : c;
  endfunction

  task automatic measureAndCheck(input int p, input int tgt);
    int c, m, win;
    fgPeriod(p);
    fgPeriod(p);
    tick(2);
    c   = expCnt(p);
    m   = tgt / 5;
    win = (c > tgt + m || c < tgt - m) ? 1 : 0;
    check("R3 period count", actualCnt, c);
    check("R4 window bit", statusByte[0], win);
    check("R5 slow bit", statusByte[1], (c > SLOW) ? 1 : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 target reset", targetCnt, 255);
    check("R1 actual reset", actualCnt, 255);
    check("R1 status reset", statusByte, 8'h02);
    check("R1 alert reset", alertN, 1);

    // R2 target write and readback
    setTarget(100);
    check("R2 target readback", targetCnt, 100);

    // R3 R4 R5 sweep of periods against two targets, detection off
    for (int i = 0; i < 82; i++) measureAndCheck(3 + 7 * i, 100);
    setTarget(37);
    check("R2 target rewrite", targetCnt, 37);
    for (int i = 0; i < 31; i++) measureAndCheck(3 + 5 * i, 37);
    check("R10 upper bits", statusByte[7:3], 0);

    // R6 long idle with detection off
    tick(2 * STALL);
    check("R6 no fail when off", alertN, 1);
    check("R6 fail bit off", statusByte[2], 0);

    // R7 stall failure
    setDet(1'b1);
    for (int i = 0; i < 20; i++) fgPeriod(50);
    check("R7 running fan no alert", alertN, 1);
    tick(STALL - 100);
    check("R7 before timeout", alertN, 1);
    tick(150);
    check("R7 stall alert", alertN, 0);
    check("R7 stall fail bit", statusByte[2], 1);
    check("R10 upper bits in fail", statusByte[7:3], 0);

    // R9 clearing sequence
    pulseAck();
    tick(2);
    check("R9 ack while enabled ignored", alertN, 0);
    setDet(1'b0);
    tick(3);
    check("R9 disable alone keeps alert", alertN, 0);
    check("R9 disable alone keeps bit", statusByte[2], 1);
    pulseAck();
    tick(1);
    check("R9 cleared alert", alertN, 1);
    check("R9 cleared bit", statusByte[2], 0);

    // R8 interrupted saturation run: no failure
    for (int i = 0; i < 3; i++) fgPeriod(50);
    setDet(1'b1);
    for (int i = 0; i < 5; i++) fgPeriod(600);
    fgPeriod(50);
    for (int i = 0; i < 8; i++) fgPeriod(600);
    check("R8 saturated count", actualCnt, 255);
    check("R8 run restarted no alert", alertN, 1);
    // eighth consecutive saturated measurement
    fgPeriod(600);
    check("R8 saturation alert", alertN, 0);
    check("R8 saturation fail bit", statusByte[2], 1);

    setDet(1'b0);
    pulseAck();
    tick(1);
    check("R9 cleared after saturation", alertN, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule